// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command, bank and address lines of a DDR SDRAM from reset until the device can take normal traffic. After reset it holds clock enable low and drives NOPs for a programmable power-up wait. It then raises clock enable and issues a fixed series of commands with NOPs between them:

1. PRECHARGE ALL.
2. Extended mode register load.
3. Base mode register load with the DLL reset bit set.
4. A second PRECHARGE ALL.
5. Two AUTO REFRESH commands.
6. A last base mode register load with the DLL reset bit cleared.

Each command is spaced from the next by the minimum gap that applies to it. The power-up wait and the gaps are counted in clock cycles and given as parameters. The mode register contents are also parameters.

The ready flag goes high only when two conditions have both been met. The gap after the final mode load must have elapsed. The DLL lock window, counted from the DLL reset command, must also have passed. Logic downstream keeps READ commands blocked until this flag is high. A synchronous reset restarts the whole program at any point.

Top module: `ddr_powerup_seq`

## Requirements
- R1: Starting from reset release, `cke` stays low and the bus carries NOP for exactly WAIT_CYC cycles. `cke` then rises and never falls again until the next reset.
- R2: The bus encoding of {cs_n, ras_n, cas_n, we_n} is: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE = 0000. When the bus carries NOP, `ba` and `addr` are zero.
- R3: The first command is PRECHARGE ALL, with `addr` = only bit 10 set and `ba` = 0. It is issued in the first cycle that `cke` is high.
- R4: T_RP cycles after the first precharge, a LOAD MODE is issued with `ba` = 2'b01 and `addr` = EMR_CODE.
- R5: T_MRD cycles after the extended load, a LOAD MODE is issued with `ba` = 0 and `addr` = MR_CODE with bit 8 forced to 1 (DLL reset).
- R6: Between two consecutive commands only NOP appears. Each command follows the previous one by exactly its gap: T_RP after PRECHARGE, T_MRD after LOAD MODE, T_RFC after AUTO REFRESH.
- R7: T_MRD cycles after the DLL reset, a second PRECHARGE ALL is issued. T_RP cycles after that comes an AUTO REFRESH, and T_RFC cycles after that comes another AUTO REFRESH.
- R8: T_RFC cycles after the second refresh, a LOAD MODE is issued with `ba` = 0 and `addr` = MR_CODE with bit 8 forced to 0. This holds even when MR_CODE has bit 8 set.
- R9: `init_done` rises in the later of two cycles: T_MRD cycles after the final mode load, or DLL_LOCK_CYC cycles after the DLL reset command. It is never high earlier.
- R10: Once `init_done` is high it stays high, and the bus stays at NOP with `cke` high.
- R11: While `rst` is high, including in the middle of the program, the outputs are `cke` = 0, NOP, `ba` = 0, `addr` = 0 and `init_done` = 0. After release the program starts again from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address / mode register code |
| init_done | output | 1 | Initialization complete; reads may start |

## Verification
The hardest behaviour to reach is the choice of which limit releases `init_done`. In one case the DLL lock window ends last; in the other, the tail of the command program ends last. The bench runs two configurations side by side, one of each kind, and compares every output on every cycle against a schedule computed from the gap parameters. One configuration also sets bit 8 in its base mode code, so the final load must clear a bit the caller asked for. A reset applied partway through the precharge-to-mode-load region must restart the program cleanly.

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq #(
  parameter int ADDR_W       = 13,
  parameter int WAIT_CYC     = 40000,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 14,
  parameter int DLL_LOCK_CYC = 200,
  parameter logic [ADDR_W-1:0] EMR_CODE = '0,
  parameter logic [ADDR_W-1:0] MR_CODE  = ADDR_W'(12'h062)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int GAP_MAX = (T_RP > T_MRD) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                          : ((T_MRD > T_RFC) ? T_MRD : T_RFC);
  localparam int CNT_MAX = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DLL_W   = $clog2(DLL_LOCK_CYC + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  localparam logic [2:0] S_PRE1 = 3'd0, S_EMR = 3'd1, S_MRDLL = 3'd2, S_PRE2 = 3'd3,
                         S_REF1 = 3'd4, S_REF2 = 3'd5, S_MRFIN = 3'd6, S_DONE = 3'd7;

  logic [ADDR_W-1:0] a10_only, mr_dll, mr_fin;
  assign a10_only = ADDR_W'(1) << 10;
  assign mr_dll   = MR_CODE | (ADDR_W'(1) << 8);
  assign mr_fin   = MR_CODE & ~(ADDR_W'(1) << 8);

  logic             cke_q;
  logic [2:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [DLL_W-1:0] dll_left;
  logic [CNT_W-1:0] gap;
  logic             issue;
  logic [3:0]       cmd;

  assign issue = cke_q && (cnt == '0) && (step != S_DONE);

  always_comb begin
    case (step)
      S_PRE1, S_PRE2: gap = CNT_W'(T_RP);
      S_REF1, S_REF2: gap = CNT_W'(T_RFC);
      default:        gap = CNT_W'(T_MRD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b0;
      step     <= S_PRE1;
      cnt      <= CNT_W'(WAIT_CYC - 1);
      dll_left <= '0;
    end else begin
      if (dll_left != '0) dll_left <= dll_left - 1'b1;
      if (!cke_q) begin
        if (cnt == '0) cke_q <= 1'b1;
        else           cnt   <= cnt - 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (step != S_DONE) begin
        step <= step + 1'b1;
        cnt  <= gap - 1'b1;
        if (step == S_MRDLL) dll_left <= DLL_W'(DLL_LOCK_CYC - 1);
      end
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    if (issue) begin
      case (step)
        S_PRE1, S_PRE2: begin cmd = C_PRE; addr = a10_only; end
        S_EMR:          begin cmd = C_LMR; ba = 2'b01; addr = EMR_CODE; end
        S_MRDLL:        begin cmd = C_LMR; addr = mr_dll; end
        S_REF1, S_REF2: cmd = C_REF;
        default:        begin cmd = C_LMR; addr = mr_fin; end
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = cke_q;
  assign init_done = (step == S_DONE) && (cnt == '0) && (dll_left == '0);

  // Independent up-counters used only by the assertions below
  logic [CNT_W:0]   since_cmd;
  logic [3:0]       last_cmd;
  logic [DLL_W:0]   dll_age;
  logic             bus_cmd;
  int               need;
  assign bus_cmd = ({cs_n, ras_n, cas_n, we_n} != C_NOP);

  always_comb begin
    case (last_cmd)
      C_PRE:   need = T_RP;
      C_REF:   need = T_RFC;
      C_LMR:   need = T_MRD;
      default: need = 0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_cmd <= '0;
      last_cmd  <= C_NOP;
      dll_age   <= '0;
    end else begin
      if (bus_cmd) begin
        since_cmd <= (CNT_W+1)'(1);
        last_cmd  <= {cs_n, ras_n, cas_n, we_n};
      end else if (since_cmd != '1) begin
        since_cmd <= since_cmd + 1'b1;
      end
      if (bus_cmd && ({cs_n, ras_n, cas_n, we_n} == C_LMR) && ba == 2'b00 && addr[8])
        dll_age <= (DLL_W+1)'(1);
      else if (dll_age != '0 && dll_age != '1)
        dll_age <= dll_age + 1'b1;
    end
  end

  p_nop_while_cke_low_r1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == C_NOP));
  p_cke_holds_r1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  p_min_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd && last_cmd != C_NOP) |-> (int'(since_cmd) >= need));
  p_dll_lockout_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (dll_age != '0 && int'(dll_age) >= DLL_LOCK_CYC));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && !bus_cmd));
endmodule

// File: tb/test_ddr_powerup_seq.sv
module test_ddr_powerup_seq;
  localparam int CLK_P = 10;
  localparam int AW = 13;

  // config 0: DLL lockout dominates; config 1: command program dominates, MR bit 8 preset
  localparam int CW   [2] = '{20, 7};
  localparam int CRP  [2] = '{3, 2};
  localparam int CMRD [2] = '{2, 1};
  localparam int CRFC [2] = '{10, 120};
  localparam int CDLL [2] = '{200, 200};
  localparam logic [AW-1:0] CEMR [2] = '{13'h0000, 13'h0002};
  localparam logic [AW-1:0] CMR  [2] = '{13'h0062, 13'h0133};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic          cke0, cs0, ras0, cas0, we0, dn0;
  logic [1:0]    ba0;
  logic [AW-1:0] ad0;
  logic          cke1, cs1, ras1, cas1, we1, dn1;
  logic [1:0]    ba1;
  logic [AW-1:0] ad1;

  ddr_powerup_seq #(.ADDR_W(AW), .WAIT_CYC(20), .T_RP(3), .T_MRD(2), .T_RFC(10),
    .DLL_LOCK_CYC(200), .EMR_CODE(13'h0000), .MR_CODE(13'h0062)) i_ddr_powerup_seq (
    .clk(clk), .rst(rst), .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0),
    .we_n(we0), .ba(ba0), .addr(ad0), .init_done(dn0));

  ddr_powerup_seq #(.ADDR_W(AW), .WAIT_CYC(7), .T_RP(2), .T_MRD(1), .T_RFC(120),
    .DLL_LOCK_CYC(200), .EMR_CODE(13'h0002), .MR_CODE(13'h0133)) i_ddr_powerup_seq_b (
    .clk(clk), .rst(rst), .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1),
    .we_n(we1), .ba(ba1), .addr(ad1), .init_done(dn1));

  int checks = 0;
  int fails  = 0;

  function automatic logic [20:0] expv(int c, int k);
    int k0, k1, k2, k3, k4, k5, k6, kd;
    logic [3:0] cmd;
    logic [1:0] b;
    logic [AW-1:0] a;
    k0 = CW[c]; k1 = k0 + CRP[c]; k2 = k1 + CMRD[c]; k3 = k2 + CMRD[c];
    k4 = k3 + CRP[c]; k5 = k4 + CRFC[c]; k6 = k5 + CRFC[c];
    kd = (k6 + CMRD[c] > k2 + CDLL[c]) ? k6 + CMRD[c] : k2 + CDLL[c];
    cmd = 4'b0111; b = 2'b00; a = '0;
    if (k == k0 || k == k3) begin cmd = 4'b0010; a = 13'h0400; end
    else if (k == k1) begin cmd = 4'b0000; b = 2'b01; a = CEMR[c]; end
    else if (k == k2) begin cmd = 4'b0000; a = CMR[c] | 13'h0100; end
    else if (k == k4 || k == k5) cmd = 4'b0001;
    else if (k == k6) begin cmd = 4'b0000; a = CMR[c] & ~13'h0100; end
    return {(k >= k0), cmd, b, a, (k >= kd)};
  endfunction

  function automatic string rq(int c, int k);
    int k0, k1, k2, k3, k4, k5, k6;
    k0 = CW[c]; k1 = k0 + CRP[c]; k2 = k1 + CMRD[c]; k3 = k2 + CMRD[c];
    k4 = k3 + CRP[c]; k5 = k4 + CRFC[c]; k6 = k5 + CRFC[c];
    if (k < k0) return "R1";
    if (k == k0) return "R3 (R2)";
    if (k == k1) return "R4 (R2)";
    if (k == k2) return "R5 (R2)";
    if (k == k3 || k == k4 || k == k5) return "R7 (R2)";
    if (k == k6) return "R8 (R2)";
    if (k > k6 + CMRD[c] && k > k2 + CDLL[c]) return "R10";
    return "R6 (R2)";
  endfunction

  task automatic chk(int c, int k, logic [20:0] act, string tag);
    logic [20:0] e;
    string t;
    e = expv(c, k);
    checks++;
    if (act !== e) begin
      fails++;
      t = tag;
      if (tag == "") t = (act[0] !== e[0]) ? "R9" : rq(c, k);
      $display("FAIL %s cfg%0d k=%0d actual=%h expected=%h", t, c, k, act, e);
    end
  endtask

  function automatic logic [20:0] pack0();
    return {cke0, cs0, ras0, cas0, we0, ba0, ad0, dn0};
  endfunction
  function automatic logic [20:0] pack1();
    return {cke1, cs1, ras1, cas1, we1, ba1, ad1, dn1};
  endfunction

  task automatic hold_reset(int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(0, 0, pack0(), "R11");
      chk(1, 0, pack1(), "R11");
    end
  endtask

  task automatic run(int n);
    rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(0, k, pack0(), "");
      chk(1, k, pack1(), "");
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    hold_reset(3);
    run(40);        // stops mid-program for both configurations
    hold_reset(2);  // R11 mid-sequence reset
    run(320);       // full program including both done cases (R9)
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule